// File: doc/BRIEF.md
# Branch Next-PC Resolution Unit

This unit works out where a program continues once a branch or jump and its delay slot have finished. It takes five inputs: the 32-bit instruction word, the address of that instruction, the two source register values the instruction names, and the floating-point control/status word. It returns the continuation address: the taken target, or the instruction address plus 8 when the branch is not taken. It also returns an optional link-register write, given as an index and a value, plus a fault flag for a misaligned instruction address and a flag for an instruction that is not a branch or jump.

The unit accepts five instruction groups. Register jumps take their target from a register. Absolute jumps splice a target field into the current 256 MB region. Other branches compare two registers, or compare one signed register against zero. The last group branches on a floating-point condition code. The surrounding pipeline owns the register file, instruction fetch, exception delivery and execution of the delay slot. It raises `req_i` with the operands. One cycle later the registered result appears together with a single-cycle `valid_o` pulse.

Top module: `brnpc_unit`

## Requirements
- R1: Synchronous active-high reset `rst` clears every output to zero.
- R2: `valid_o` is 1 in exactly the cycle after a cycle with `req_i` = 1, and 0 otherwise. While no request is made, all other outputs hold their last values.
- R3: If `pc_i[1:0]` is nonzero, `align_fault_o` = 1, `link_we_o` = 0, `unsup_o` = 0 and `next_pc_o` = `pc_i`.
- R4: A taken conditional branch resolves to `pc_i` + 4 + (sign-extended `instr_i[15:0]` shifted left by 2). A not-taken conditional branch resolves to `pc_i` + 8.
- R5: Opcode `instr_i[31:26]` = 0 with function `instr_i[5:0]` = 8 (jump register) or 9 (jump register and link) resolves to `src_a_i`. Function 9 also writes `pc_i` + 8 to the register index `instr_i[15:11]`.
- R6: Opcodes 2 (jump) and 3 (jump and link) resolve to {(`pc_i`+4)[31:28], `instr_i[25:0]`, 2'b00}. Opcode 3 writes `pc_i` + 8 to register 31.
- R7: Opcode 1 decodes `instr_i[20:16]`: 0, 2, 16 and 18 branch when `src_a_i` is negative (signed); 1, 3, 17 and 19 branch when `src_a_i` >= 0. Codes 16 to 19 write `pc_i` + 8 to register 31 whether or not the branch is taken.
- R8: Opcode 4 branches when `src_a_i` == `src_b_i` and opcode 5 when they differ. Opcode 6 branches when signed `src_a_i` <= 0 and opcode 7 when it is > 0. For opcodes 6 and 7, `instr_i[20:16]` has no effect.
- R9: The likely opcodes 20, 21, 22 and 23 give exactly the results of opcodes 4, 5, 6 and 7. Likely codes 2, 3, 18 and 19 under opcode 1, and `instr_i[17]` = 1 under opcode 17, give exactly the results of their ordinary forms.
- R10: Opcode 17 with `instr_i[25:21]` = 8 is a condition-code branch. The index is k = `instr_i[20:18]`. The tested bit of `fcsr_i` is bit 23 when k = 0 and bit 24+k otherwise. `instr_i[16]` = 1 branches when that bit is set; 0 branches when it is clear.
- R11: Any other instruction sets `unsup_o` = 1, `link_we_o` = 0 and `next_pc_o` = `pc_i`.
- R12: Branches and jumps without a link form leave `link_we_o` = 0, and `unsup_o` and `align_fault_o` are 0 for every recognised, aligned instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Resolve request strobe |
| instr_i | input | 32 | Branch or jump instruction word |
| pc_i | input | 32 | Address of the instruction |
| src_a_i | input | 32 | Value of the first source register |
| src_b_i | input | 32 | Value of the second source register |
| fcsr_i | input | 32 | Floating-point control/status word |
| valid_o | output | 1 | Result valid, one cycle after the request |
| next_pc_o | output | 32 | Continuation address after the delay slot |
| link_we_o | output | 1 | Link register write requested |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value |
| align_fault_o | output | 1 | Instruction address not word aligned |
| unsup_o | output | 1 | Instruction is not a branch or jump |

## Verification
The assertions check the handshake timing and the hold-when-idle rule on every cycle. They also check that a fault or an unsupported instruction suppresses the link write and keeps the input address, and that any link value equals the requesting address plus 8. Some behaviour only the bench's vectors can show: the choice between taken and not-taken for each comparison, the sign-extended offset arithmetic, the region splice of absolute jumps, and the condition-code bit mapping that skips bit 24. The bench also shows that rt has no effect on the zero-compare branches and that the likely forms match their ordinary ones.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int NUM_CC   = 8;
    localparam int CC_IDX_W = $clog2(NUM_CC);
    localparam int LINK_REG = 31;

    localparam logic [5:0] OP_SPECIAL = 6'd0;
    localparam logic [5:0] OP_REGIMM  = 6'd1;
    localparam logic [5:0] OP_J       = 6'd2;
    localparam logic [5:0] OP_JAL     = 6'd3;
    localparam logic [5:0] OP_BEQ     = 6'd4;
    localparam logic [5:0] OP_BNE     = 6'd5;
    localparam logic [5:0] OP_BLEZ    = 6'd6;
    localparam logic [5:0] OP_BGTZ    = 6'd7;
    localparam logic [5:0] OP_COP1    = 6'd17;
    localparam logic [5:0] OP_BEQL    = 6'd20;
    localparam logic [5:0] OP_BNEL    = 6'd21;
    localparam logic [5:0] OP_BLEZL   = 6'd22;
    localparam logic [5:0] OP_BGTZL   = 6'd23;
    localparam logic [5:0] FN_JR      = 6'd8;
    localparam logic [5:0] FN_JALR    = 6'd9;
    localparam logic [4:0] COP1_BC    = 5'd8;

    typedef enum logic [3:0] {
        K_NONE, K_JR, K_JALR, K_J, K_JAL,
        K_BEQ, K_BNE, K_BLEZ, K_BGTZ, K_BLTZ, K_BGEZ, K_FPCC
    } kind_e;

    typedef struct packed {
        kind_e                kind;
        logic                 cond_link;
        logic                 fp_on_true;
        logic [CC_IDX_W-1:0]  fp_idx;
        logic [15:0]          imm;
        logic [25:0]          target;
        logic [RIDX_W-1:0]    rd;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0]   next_pc;
        logic              link_we;
        logic [RIDX_W-1:0] link_idx;
        logic [XLEN-1:0]   link_val;
        logic              fault;
        logic              unsup;
    } res_t;

    function automatic int unsigned cc_bit_pos(int unsigned idx);
        return (idx == 0) ? 23 : 24 + idx;
    endfunction

endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
    import brnpc_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic [5:0] op;
    logic [4:0] rs;
    logic [4:0] rt;
    logic [5:0] fn;

    assign op = instr[31:26];
    assign rs = instr[25:21];
    assign rt = instr[20:16];
    assign fn = instr[5:0];

    always_comb begin
        dec            = '0;
        dec.kind       = K_NONE;
        dec.imm        = instr[15:0];
        dec.target     = instr[25:0];
        dec.rd         = instr[15:11];
        dec.fp_idx     = rt[4:2];
        dec.fp_on_true = rt[0];
        dec.cond_link  = rt[4];
        unique case (op)
            OP_SPECIAL: begin
                if (fn == FN_JR)        dec.kind = K_JR;
                else if (fn == FN_JALR) dec.kind = K_JALR;
            end
            OP_REGIMM: begin
                if (rt[3:2] == 2'b00)
                    dec.kind = rt[0] ? K_BGEZ : K_BLTZ;
            end
            OP_J:                dec.kind = K_J;
            OP_JAL:              dec.kind = K_JAL;
            OP_BEQ,  OP_BEQL:    dec.kind = K_BEQ;
            OP_BNE,  OP_BNEL:    dec.kind = K_BNE;
            OP_BLEZ, OP_BLEZL:   dec.kind = K_BLEZ;
            OP_BGTZ, OP_BGTZL:   dec.kind = K_BGTZ;
            OP_COP1: begin
                if (rs == COP1_BC) dec.kind = K_FPCC;
            end
            default:             dec.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/brnpc_resolve.sv
module brnpc_resolve
    import brnpc_pkg::*;
(
    input  dec_t              dec,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   src_a,
    input  logic [XLEN-1:0]   src_b,
    input  logic [NUM_CC-1:0] cc,
    output res_t              res
);
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] pc_plus8;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic            a_neg;
    logic            a_zero;
    logic            taken;
    logic            is_branch;

    assign pc_plus4   = pc + XLEN'(4);
    assign pc_plus8   = pc + XLEN'(8);
    assign br_target  = pc_plus4 + {{(XLEN-18){dec.imm[15]}}, dec.imm, 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], dec.target, 2'b00};
    assign a_neg      = src_a[XLEN-1];
    assign a_zero     = (src_a == '0);

    always_comb begin
        taken     = 1'b0;
        is_branch = 1'b1;
        unique case (dec.kind)
            K_BEQ:   taken = (src_a == src_b);
            K_BNE:   taken = (src_a != src_b);
            K_BLEZ:  taken = a_neg || a_zero;
            K_BGTZ:  taken = !a_neg && !a_zero;
            K_BLTZ:  taken = a_neg;
            K_BGEZ:  taken = !a_neg;
            K_FPCC:  taken = (cc[dec.fp_idx] == dec.fp_on_true);
            default: is_branch = 1'b0;
        endcase
    end

    always_comb begin
        res          = '0;
        res.next_pc  = pc;
        res.link_val = pc_plus8;
        if (pc[1:0] != 2'b00) begin
            res.fault = 1'b1;
        end else if (is_branch) begin
            res.next_pc = taken ? br_target : pc_plus8;
            if ((dec.kind == K_BLTZ || dec.kind == K_BGEZ) && dec.cond_link) begin
                res.link_we  = 1'b1;
                res.link_idx = RIDX_W'(LINK_REG);
            end
        end else begin
            unique case (dec.kind)
                K_JR:   res.next_pc = src_a;
                K_JALR: begin
                    res.next_pc  = src_a;
                    res.link_we  = 1'b1;
                    res.link_idx = dec.rd;
                end
                K_J:    res.next_pc = jmp_target;
                K_JAL: begin
                    res.next_pc  = jmp_target;
                    res.link_we  = 1'b1;
                    res.link_idx = RIDX_W'(LINK_REG);
                end
                default: res.unsup = 1'b1;
            endcase
        end
        if (!res.link_we) res.link_val = '0;
    end

    always_comb begin
        AST_FAULT_BLOCKS_LINK: assert (!(res.fault && (res.link_we || res.unsup))); // R3
    end

endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
    import brnpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic [31:0]       instr_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   src_a_i,
    input  logic [XLEN-1:0]   src_b_i,
    input  logic [XLEN-1:0]   fcsr_i,
    output logic              valid_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              link_we_o,
    output logic [RIDX_W-1:0] link_idx_o,
    output logic [XLEN-1:0]   link_val_o,
    output logic              align_fault_o,
    output logic              unsup_o
);
    logic [NUM_CC-1:0] cc_vec;
    dec_t              dec;
    res_t              res;
    res_t              res_q;
    logic              valid_q;

    for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
        assign cc_vec[g] = fcsr_i[cc_bit_pos(g)];
    end

    brnpc_decode u_decode (
        .instr (instr_i),
        .dec   (dec)
    );

    brnpc_resolve u_resolve (
        .dec   (dec),
        .pc    (pc_i),
        .src_a (src_a_i),
        .src_b (src_b_i),
        .cc    (cc_vec),
        .res   (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_i;
            if (req_i) res_q <= res;
        end
    end

    assign valid_o       = valid_q;
    assign next_pc_o     = res_q.next_pc;
    assign link_we_o     = res_q.link_we;
    assign link_idx_o    = res_q.link_idx;
    assign link_val_o    = res_q.link_val;
    assign align_fault_o = res_q.fault;
    assign unsup_o       = res_q.unsup;

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_i |=> valid_o); // R2
    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> !valid_o); // R2
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> $stable(next_pc_o) && $stable(link_we_o) && $stable(unsup_o)); // R2
    AST_FAULT_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
        valid_o && align_fault_o |-> next_pc_o == $past(pc_i) && !link_we_o && !unsup_o); // R3
    AST_LINK_IS_PC8: assert property (@(posedge clk) disable iff (rst)
        valid_o && link_we_o |-> link_val_o == $past(pc_i) + XLEN'(8)); // R5
    AST_UNSUP_KEEPS_PC: assert property (@(posedge clk) disable iff (rst)
        valid_o && unsup_o |-> next_pc_o == $past(pc_i) && !link_we_o && !align_fault_o); // R11

endmodule

// File: tb/brnpc_unit_tb.sv
module brnpc_unit_tb_top;

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] fcsr;
        logic [31:0] nxt;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        logic        flt;
        logic        uns;
        logic [7:0]  rq;
    } vec_t;

    function automatic logic [31:0] fi(int op, int rs, int rt, logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] fr(int rs, int rd, int fn);
        return {6'd0, 5'(rs), 5'd0, 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] fj(int op, logic [25:0] t);
        return {6'(op), t};
    endfunction
    function automatic vec_t mkv(logic [31:0] ins, logic [31:0] pc, logic [31:0] a,
                                 logic [31:0] b, logic [31:0] fc, logic [31:0] nx,
                                 logic we, logic [4:0] ix, logic [31:0] vl,
                                 logic fl, logic un, int rq);
        return '{ins, pc, a, b, fc, nx, we, ix, vl, fl, un, 8'(rq)};
    endfunction

    localparam int NV = 31;
    localparam logic [31:0] P = 32'h0000_1000;
    localparam vec_t VECS [0:NV-1] = '{
        mkv(fi(4,1,2,16'h0010), P, 5, 5, 0, 32'h1044, 0, 0, 0, 0, 0, 4),      // R4 R8 beq taken
        mkv(fi(4,1,2,16'h0010), P, 5, 6, 0, 32'h1008, 0, 0, 0, 0, 0, 4),      // R4 beq not taken
        mkv(fi(5,1,2,16'hFFFF), P, 1, 2, 0, 32'h1000, 0, 0, 0, 0, 0, 8),      // R8 bne negative offset
        mkv(fi(6,1,5,16'h0002), P, 0, 0, 0, 32'h100C, 0, 0, 0, 0, 0, 8),      // R8 blez zero, rt ignored
        mkv(fi(6,1,5,16'h0002), P, 1, 0, 0, 32'h1008, 0, 0, 0, 0, 0, 8),      // R8 blez positive
        mkv(fi(7,1,0,16'h0002), P, 32'h8000_0000, 0, 0, 32'h1008, 0, 0, 0, 0, 0, 8), // R8 bgtz negative
        mkv(fi(7,1,9,16'h8000), 32'h0004_0000, 7, 0, 0, 32'h0002_0004, 0, 0, 0, 0, 0, 4), // R4 min offset
        mkv(fi(20,1,2,16'h0003), P, 3, 3, 0, 32'h1010, 0, 0, 0, 0, 0, 9),     // R9 beql
        mkv(fi(23,1,0,16'h0004), P, 1, 0, 0, 32'h1014, 0, 0, 0, 0, 0, 9),     // R9 bgtzl
        mkv(fi(1,1,0,16'h0008), P, 32'hFFFF_FFFF, 0, 0, 32'h1024, 0, 0, 0, 0, 0, 7), // R7 bltz
        mkv(fi(1,1,1,16'h0008), P, 32'hFFFF_FFFF, 0, 0, 32'h1008, 0, 0, 0, 0, 0, 7), // R7 bgez
        mkv(fi(1,1,16,16'h0008), P, 5, 0, 0, 32'h1008, 1, 31, 32'h1008, 0, 0, 7),    // R7 link when not taken
        mkv(fi(1,1,19,16'h0010), P, 0, 0, 0, 32'h1044, 1, 31, 32'h1008, 0, 0, 9),    // R9 bgezall
        mkv(fi(1,1,3,16'h0002), P, 0, 0, 0, 32'h100C, 0, 0, 0, 0, 0, 9),      // R9 bgezl
        mkv(fi(1,1,4,16'h0002), P, 0, 0, 0, P, 0, 0, 0, 0, 1, 11),            // R11 regimm rt 4
        mkv(fr(3,0,8), P, 32'h1234_5678, 0, 0, 32'h1234_5678, 0, 0, 0, 0, 0, 5), // R5 jr
        mkv(fr(3,7,9), P, 32'h0000_2000, 0, 0, 32'h2000, 1, 7, 32'h1008, 0, 0, 5), // R5 jalr
        mkv(fj(2,26'h0ABCDE), 32'hA000_0FFC, 0, 0, 0, 32'hA02A_F378, 0, 0, 0, 0, 0, 6), // R6 j
        mkv(fj(3,26'h3FFFFFF), 32'hEFFF_FFFC, 0, 0, 0, 32'hFFFF_FFFC, 1, 31, 32'hF000_0004, 0, 0, 6), // R6 jal
        mkv(fr(3,7,32), P, 0, 0, 0, P, 0, 0, 0, 0, 1, 11),                    // R11 special func 32
        mkv(fi(8,1,2,16'h0004), P, 0, 0, 0, P, 0, 0, 0, 0, 1, 11),            // R11 opcode 8
        mkv(fi(4,1,2,16'h0010), 32'h1002, 5, 5, 0, 32'h1002, 0, 0, 0, 1, 0, 3),   // R3 beq misaligned
        mkv(fj(3,26'h10), 32'h1001, 0, 0, 0, 32'h1001, 0, 0, 0, 1, 0, 3),     // R3 jal misaligned
        mkv(fi(17,8,0,16'h0002), P, 0, 0, 0, 32'h100C, 0, 0, 0, 0, 0, 10),    // R10 false, cc0 clear
        mkv(fi(17,8,1,16'h0002), P, 0, 0, 32'h0080_0000, 32'h100C, 0, 0, 0, 0, 0, 10), // R10 bit 23
        mkv(fi(17,8,1,16'h0002), P, 0, 0, 32'h0200_0000, 32'h1008, 0, 0, 0, 0, 0, 10), // R10 cc0 ignores 25
        mkv(fi(17,8,5,16'h0002), P, 0, 0, 32'h0200_0000, 32'h100C, 0, 0, 0, 0, 0, 10), // R10 cc1 is bit 25
        mkv(fi(17,8,4,16'h0002), P, 0, 0, 32'h0100_0000, 32'h100C, 0, 0, 0, 0, 0, 10), // R10 bit 24 unused
        mkv(fi(17,8,31,16'h0003), P, 0, 0, 32'h8000_0000, 32'h1010, 0, 0, 0, 0, 0, 9), // R9 true likely cc7
        mkv(fi(17,8,30,16'h0003), P, 0, 0, 32'h8000_0000, 32'h1008, 0, 0, 0, 0, 0, 10), // R10 false likely cc7
        mkv(fi(17,0,1,16'h0003), P, 0, 0, 32'h0080_0000, P, 0, 0, 0, 0, 1, 11)  // R11 cop1 non-branch
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_i;
    logic [31:0] instr_i, pc_i, src_a_i, src_b_i, fcsr_i;
    logic        valid_o;
    logic [31:0] next_pc_o;
    logic        link_we_o;
    logic [4:0]  link_idx_o;
    logic [31:0] link_val_o;
    logic        align_fault_o;
    logic        unsup_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    brnpc_unit dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .instr_i(instr_i), .pc_i(pc_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .fcsr_i(fcsr_i), .valid_o(valid_o),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_val_o(link_val_o), .align_fault_o(align_fault_o), .unsup_o(unsup_o)
    );

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic check_outs(string tag, vec_t v);
        check({tag, " valid"},    32'(valid_o), 32'd1);
        check({tag, " next_pc"},  next_pc_o, v.nxt);
        check({tag, " link_we"},  32'(link_we_o), 32'(v.we));
        check({tag, " link_idx"}, 32'(link_idx_o), 32'(v.idx));
        check({tag, " link_val"}, link_val_o, v.val);
        check({tag, " fault"},    32'(align_fault_o), 32'(v.flt));
        check({tag, " unsup"},    32'(unsup_o), 32'(v.uns));
    endtask

    task automatic drive(vec_t v);
        instr_i = v.instr; pc_i = v.pc; src_a_i = v.a; src_b_i = v.b; fcsr_i = v.fcsr;
        req_i = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        vec_t held;
        rst = 1'b1; req_i = 1'b1;
        instr_i = fj(3, 26'h55); pc_i = P; src_a_i = 0; src_b_i = 0; fcsr_i = 0;
        repeat (3) @(negedge clk);
        // R1: reset clears everything, even with a request pending
        check("R1 valid", 32'(valid_o), 0);
        check("R1 next_pc", next_pc_o, 0);
        check("R1 link", {link_we_o, link_idx_o, align_fault_o, unsup_o}, 0);
        check("R1 link_val", link_val_o, 0);
        req_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2 no request no valid", 32'(valid_o), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_outs($sformatf("vec %0d R%0d", i, VECS[i].rq), VECS[i]);
        end

        // R2: idle cycles hold the last result and drop valid
        held = VECS[NV-1];
        req_i = 1'b0; instr_i = fj(2, 26'h1234); pc_i = 32'h0000_8000;
        @(negedge clk);
        check("R2 valid drops", 32'(valid_o), 0);
        check("R2 next_pc held", next_pc_o, held.nxt);
        check("R2 unsup held", 32'(unsup_o), 32'(held.uns));
        @(negedge clk);
        check("R2 still held", next_pc_o, held.nxt);

        // R2: back-to-back requests each give one result
        drive(VECS[0]);
        @(negedge clk);
        check_outs("R2 b2b first", VECS[0]);
        drive(VECS[16]);
        @(negedge clk);
        check_outs("R2 b2b second R5", VECS[16]);
        req_i = 1'b0;
        @(negedge clk);
        check("R2 single pulse", 32'(valid_o), 0);

        // R12: a jump with no link after a linking one clears link_we
        drive(VECS[15]);
        @(negedge clk);
        check("R12 jr no link", 32'(link_we_o), 0);
        req_i = 1'b0;

        // R1: reset mid-operation
        drive(VECS[18]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid valid", 32'(valid_o), 0);
        check("R1 reset mid link", 32'(link_we_o), 0);
        check("R1 reset mid pc", next_pc_o, 0);
        rst = 1'b0; req_i = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule